// File: doc/BRIEF.md
# Maskable Interrupt and Status Controller

This block gathers asynchronous event sources and turns them into host-readable status flags and one interrupt pin. The sources are a vector of per-channel overflow indications, a level signal that reports whether the rate converters are locked, and a small set of general-purpose input pins. Every source passes through a synchroniser. Each source is then captured as a level-sensitive flag, which follows the input, or as an edge-sensitive flag, which is set on a rising edge and held until the host reads it.

The host reaches the block through a simple strobe port. A write strobe with an address and data updates a configuration register. A read strobe returns the addressed register in the same cycle, and the clock edge that ends the read clears the edge-sensitive flags of that register. The interrupt pin is active while any unmasked status flag is set. It can drive active low, drive active high, or act as an open-drain active-low output. In open-drain mode the block drives the pin value low and uses an output enable.

Register map (3-bit address): 0 config (bits 1:0 pin mode, bit 2 overflow edge select), 1 event mask (bit 0 lock, bit 1 unlock, bit 2 overflow summary), 2 event status (read-only), 3 overflow status (read-only), 4 GPIO edge select, 5 GPIO mask, 6 GPIO status (read-only). Unused read bits return 0.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every register at addresses 0 to 6 reads 0, and the pin is in active-low mode and idle (irqOut=1, irqOe=1).
- R2: Pin mode encoding, where "any" means an unmasked flag is set:
  - Mode 0 (and reserved mode 3): irqOut=~any, irqOe=1.
  - Mode 1: irqOut=any, irqOe=1.
  - Mode 2: irqOut=0, irqOe=any.
- R3: Mask gating (a mask bit of 1 enables its source):
  - Lock and unlock flags set only while their mask bit is 1, and the same holds for each GPIO status bit.
  - Event status bit 2 reads as the OR of the overflow status bits ANDed with mask bit 2.
  - The per-channel overflow status records events whatever the mask.
- R4: With config bit 2 at 0 (level), overflow status bit i equals overflow input i as sampled three clock edges earlier, and a read does not clear it.
- R5: With config bit 2 at 1 (edge), a rising overflow input sets its status bit. The bit stays set after the input falls and clears at the edge that ends a read of address 3.
- R6: If a new rising edge is detected in the same cycle as the read that clears its register, the bit is left set.
- R7: GPIO edge select bit i picks edge mode (1) or level mode (0, the reset value) for pin i, with the behaviour of R4 and R5, cleared by a read of address 6.
- R8: Lock and unlock flags:
  - A rising edge of srcLock sets the lock flag, which is bit 0 of the event status.
  - A falling edge sets the unlock flag, which is bit 1.
  - Each event clears the other flag without a host read.
  - A read of address 2 clears both flags.
- R9: The pin is active exactly when some status bit ANDed with its mask is set. Clearing a mask bit silences the pin but leaves the status readable.
- R10: The writable registers (addresses 0, 1, 4 and 5) read back the written value in their defined bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears edge flags of the addressed status register) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current address |
| ovflIn | input | 8 | Per-channel overflow event inputs |
| gpioIn | input | 4 | General-purpose event input pins |
| srcLock | input | 1 | Converter lock level (high = all active converters locked) |
| irqOut | output | 1 | Interrupt pin value |
| irqOe | output | 1 | Interrupt pin output enable |

## Verification
The assertions assume the event inputs are levels that each synchroniser stage samples at clock edges. They also assume a source is never pulsed shorter than one clock period. The level-mode latency check further relies on a synchroniser depth of two. The stimulus changes inputs only on falling clock edges and holds every pulse for a full cycle. Before reading a status register it waits at least three rising edges. Only the same-cycle read-and-event case times its read to coincide with the capture edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_CFG       = 3'd0;
  localparam logic [ADDR_W-1:0] REG_EVT_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_EVT_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_OVFL_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] REG_GPIO_SEL  = 3'd4;
  localparam logic [ADDR_W-1:0] REG_GPIO_MASK = 3'd5;
  localparam logic [ADDR_W-1:0] REG_GPIO_STAT = 3'd6;

  typedef enum logic [1:0] {
    PIN_ACT_LOW    = 2'd0,
    PIN_ACT_HIGH   = 2'd1,
    PIN_OPEN_DRAIN = 2'd2,
    PIN_RSVD       = 2'd3
  } pin_mode_e;

  // read-clear strobes from control to datapath
  typedef struct packed {
    logic clrEvt;
    logic clrOvfl;
    logic clrGpio;
  } clr_strobe_t;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_GPIO = 4,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [2:0]          evtStat,
  input  logic [NUM_CH-1:0]   ovflStat,
  input  logic [NUM_GPIO-1:0] gpioStat,
  output clr_strobe_t         strb,
  output pin_mode_e           pinMode,
  output logic                ovflEdge,
  output logic [2:0]          evtMask,
  output logic [NUM_GPIO-1:0] gpioSel,
  output logic [NUM_GPIO-1:0] gpioMask
);

  logic unusedWr;
  assign unusedWr = &{1'b0, wrData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinMode  <= PIN_ACT_LOW;
      ovflEdge <= 1'b0;
      evtMask  <= '0;
      gpioSel  <= '0;
      gpioMask <= '0;
    end else if (wrEn) begin
      case (addr)
        REG_CFG: begin
          pinMode  <= pin_mode_e'(wrData[1:0]);
          ovflEdge <= wrData[2];
        end
        REG_EVT_MASK:  evtMask  <= wrData[2:0];
        REG_GPIO_SEL:  gpioSel  <= wrData[NUM_GPIO-1:0];
        REG_GPIO_MASK: gpioMask <= wrData[NUM_GPIO-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.clrEvt  = rdEn && (addr == REG_EVT_STAT);
    strb.clrOvfl = rdEn && (addr == REG_OVFL_STAT);
    strb.clrGpio = rdEn && (addr == REG_GPIO_STAT);
  end

  always_comb begin
    rdData = '0;
    case (addr)
      REG_CFG:       rdData[2:0] = {ovflEdge, pinMode};
      REG_EVT_MASK:  rdData[2:0] = evtMask;
      REG_EVT_STAT:  rdData[2:0] = evtStat;
      REG_OVFL_STAT: rdData[NUM_CH-1:0] = ovflStat;
      REG_GPIO_SEL:  rdData[NUM_GPIO-1:0] = gpioSel;
      REG_GPIO_MASK: rdData[NUM_GPIO-1:0] = gpioMask;
      REG_GPIO_STAT: rdData[NUM_GPIO-1:0] = gpioStat;
      default:       rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_GPIO    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   ovflIn,
  input  logic [NUM_GPIO-1:0] gpioIn,
  input  logic                srcLock,
  input  clr_strobe_t         strb,
  input  pin_mode_e           pinMode,
  input  logic                ovflEdge,
  input  logic [2:0]          evtMask,
  input  logic [NUM_GPIO-1:0] gpioSel,
  input  logic [NUM_GPIO-1:0] gpioMask,
  output logic [NUM_CH-1:0]   ovflStat,
  output logic [NUM_GPIO-1:0] gpioStat,
  output logic [2:0]          evtStat,
  output logic                irqOut,
  output logic                irqOe
);

  localparam int NSRC     = NUM_CH + NUM_GPIO + 1;
  localparam int GPIO_LSB = NUM_CH;
  localparam int LOCK_IDX = NSRC - 1;

  logic [NSRC-1:0] rawIn, syncd, prevQ, riseV, fallV;
  logic [SYNC_STAGES-1:0][NSRC-1:0] syncQ;

  assign rawIn = {srcLock, gpioIn, ovflIn};

  // synchroniser chain plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= rawIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncd;
    end
  end

  assign syncd = syncQ[SYNC_STAGES-1];
  assign riseV = syncd & ~prevQ;
  assign fallV = ~syncd & prevQ;

  logic [NUM_CH-1:0]   ovflSync, ovflRise, ovflNext;
  logic [NUM_GPIO-1:0] gpioSync, gpioRise, gpioNext;
  logic lockRise, lockFall, lockQ, unlockQ, lockNext, unlockNext;

  assign ovflSync = syncd[NUM_CH-1:0];
  assign ovflRise = riseV[NUM_CH-1:0];
  assign gpioSync = syncd[GPIO_LSB +: NUM_GPIO];
  assign gpioRise = riseV[GPIO_LSB +: NUM_GPIO];
  assign lockRise = riseV[LOCK_IDX];
  assign lockFall = fallV[LOCK_IDX];

  always_comb begin
    // overflow: records regardless of mask; a rise beats a same-cycle clear
    if (ovflEdge)
      ovflNext = (ovflStat & ~{NUM_CH{strb.clrOvfl}}) | ovflRise;
    else
      ovflNext = ovflSync;

    gpioNext = (gpioSel & ((gpioStat & ~{NUM_GPIO{strb.clrGpio}}) | (gpioRise & gpioMask)))
             | (~gpioSel & gpioSync & gpioMask);

    // lock and unlock events cancel each other's pending flag
    lockNext   = (lockRise & evtMask[0]) | (lockQ & ~strb.clrEvt & ~lockFall);
    unlockNext = (lockFall & evtMask[1]) | (unlockQ & ~strb.clrEvt & ~lockRise);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovflStat <= '0;
      gpioStat <= '0;
      lockQ    <= 1'b0;
      unlockQ  <= 1'b0;
    end else begin
      ovflStat <= ovflNext;
      gpioStat <= gpioNext;
      lockQ    <= lockNext;
      unlockQ  <= unlockNext;
    end
  end

  assign evtStat = {(|ovflStat) & evtMask[2], unlockQ, lockQ};

  logic irqAny;
  assign irqAny = (|(evtStat & evtMask)) | (|(gpioStat & gpioMask));

  always_comb begin
    case (pinMode)
      PIN_ACT_HIGH: begin
        irqOut = irqAny;
        irqOe  = 1'b1;
      end
      PIN_OPEN_DRAIN: begin
        irqOut = 1'b0;
        irqOe  = irqAny;
      end
      default: begin
        irqOut = ~irqAny;
        irqOe  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_GPIO    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_CH-1:0]   ovflIn,
  input  logic [NUM_GPIO-1:0] gpioIn,
  input  logic                srcLock,
  output logic                irqOut,
  output logic                irqOe
);

  clr_strobe_t         strb;
  pin_mode_e           pinMode;
  logic                ovflEdge;
  logic [2:0]          evtMask, evtStat;
  logic [NUM_GPIO-1:0] gpioSel, gpioMask, gpioStat;
  logic [NUM_CH-1:0]   ovflStat;

  irq_ctrl #(.NUM_CH(NUM_CH), .NUM_GPIO(NUM_GPIO), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtStat(evtStat), .ovflStat(ovflStat),
    .gpioStat(gpioStat), .strb(strb), .pinMode(pinMode), .ovflEdge(ovflEdge),
    .evtMask(evtMask), .gpioSel(gpioSel), .gpioMask(gpioMask)
  );

  irq_datapath #(.NUM_CH(NUM_CH), .NUM_GPIO(NUM_GPIO), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .ovflIn(ovflIn), .gpioIn(gpioIn), .srcLock(srcLock),
    .strb(strb), .pinMode(pinMode), .ovflEdge(ovflEdge), .evtMask(evtMask),
    .gpioSel(gpioSel), .gpioMask(gpioMask), .ovflStat(ovflStat),
    .gpioStat(gpioStat), .evtStat(evtStat), .irqOut(irqOut), .irqOe(irqOe)
  );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_GPIO    = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_CH-1:0]   ovflIn,
  input logic                irqOut,
  input logic                irqOe,
  input pin_mode_e           pinMode,
  input logic                ovflEdge,
  input logic [NUM_CH-1:0]   ovflStat,
  input logic [2:0]          evtStat,
  input logic [NUM_GPIO-1:0] gpioStat,
  input logic [NUM_GPIO-1:0] gpioMask
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R2
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinMode == PIN_OPEN_DRAIN) |-> !irqOut);

  // R2
  push_pull_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinMode != PIN_OPEN_DRAIN) |-> irqOe);

  // R9
  idle_when_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtStat == 3'b000 && gpioStat == '0 && pinMode == PIN_OPEN_DRAIN) |-> !irqOe);

  // R8
  lock_unlock_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(evtStat[0] && evtStat[1]));

  // R5
  ovfl_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovflEdge && !(rdEn && addr == REG_OVFL_STAT))
      |=> ((ovflStat & $past(ovflStat)) == $past(ovflStat)));

  // R3
  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio
    gpio_mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gpioStat[g]) |-> $past(gpioMask[g]));
  end

  if (SYNC_STAGES == 2) begin : g_lat
    // R4
    ovfl_level_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst == 2'd3 && $past(!ovflEdge)) |-> (ovflStat == $past(ovflIn, 3)));
  end

endmodule

bind irq_status_ctrl irq_status_chk #(
  .NUM_CH(NUM_CH), .NUM_GPIO(NUM_GPIO), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .ovflIn(ovflIn),
  .irqOut(irqOut), .irqOe(irqOe), .pinMode(pinMode), .ovflEdge(ovflEdge),
  .ovflStat(ovflStat), .evtStat(evtStat), .gpioStat(gpioStat), .gpioMask(gpioMask)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;

  logic       clk = 1'b0;
  logic       rstN, wrEn, rdEn, srcLock;
  logic [2:0] addr;
  logic [7:0] wrData, rdData, ovflIn;
  logic [3:0] gpioIn;
  logic       irqOut, irqOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ovflIn(ovflIn), .gpioIn(gpioIn),
    .srcLock(srcLock), .irqOut(irqOut), .irqOe(irqOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // expected {irqOut, irqOe}
  function automatic logic [1:0] pinExp(input int mode, input bit any);
    case (mode)
      1:       return {any, 1'b1};
      2:       return {1'b0, any};
      default: return {~any, 1'b1};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    ovflIn = '0; gpioIn = '0; srcLock = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg %0d", a), d, 0);
    end
    check("R1 pin idle", {irqOut, irqOe}, 2'b11);

    // R10 readback sweeps
    for (int v = 0; v < 16; v++) begin
      wr(3'd5, 8'(v)); rd(3'd5, d); check("R10 gpio mask", d, v);
      wr(3'd4, 8'(v)); rd(3'd4, d); check("R10 gpio sel", d, v);
    end
    for (int v = 0; v < 8; v++) begin
      wr(3'd1, 8'(v)); rd(3'd1, d); check("R10 evt mask", d, v);
      wr(3'd0, 8'(v)); rd(3'd0, d); check("R10 cfg", d, v);
    end
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);

    // R2 pin modes, GPIO level source
    wr(3'd5, 8'h0F);
    for (int m = 0; m < 4; m++) begin
      for (int act = 0; act < 2; act++) begin
        wr(3'd0, 8'(m));
        gpioIn = act[0] ? 4'hF : 4'h0;
        tick(3);
        check($sformatf("R2 mode %0d act %0d", m, act), {irqOut, irqOe}, pinExp(m, act[0]));
      end
    end
    gpioIn = 4'h0; tick(3);
    wr(3'd0, 8'h00);

    // R7 per-pin level/edge select sweep
    for (int s = 0; s < 16; s++) begin
      wr(3'd4, 8'(s));
      gpioIn = 4'hF; tick(3);
      rd(3'd6, d); check("R7 all set", d, 8'h0F);
      rd(3'd6, d); check("R7 edge bits cleared by read", d, (~s) & 8'h0F);
      gpioIn = 4'h0; tick(3);
      rd(3'd6, d); check("R7 all clear", d, 0);
      check("R9 idle pin", {irqOut, irqOe}, 2'b11);
    end

    // R3 GPIO mask sweep, all pins edge
    wr(3'd4, 8'h0F);
    for (int m = 0; m < 16; m++) begin
      wr(3'd5, 8'(m));
      gpioIn = 4'hF; tick(1); gpioIn = 4'h0; tick(3);
      check("R9 pin follows masked status", {irqOut, irqOe}, pinExp(0, m != 0));
      rd(3'd6, d); check("R3 gpio masked capture", d, m);
      rd(3'd6, d); check("R5 gpio read clear", d, 0);
    end

    // R9 masking after capture silences pin, status still readable
    wr(3'd5, 8'h0F);
    gpioIn = 4'hF; tick(1); gpioIn = 4'h0; tick(3);
    wr(3'd5, 8'h00);
    check("R9 masked pin idle", {irqOut, irqOe}, 2'b11);
    rd(3'd6, d); check("R9 status kept", d, 8'h0F);

    // R4 overflow level mode
    wr(3'd1, 8'h04); wr(3'd0, 8'h00);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] p;
      p = 8'((i * 8'h2B) ^ (i == 7 ? 8'h00 : 8'h00));
      if (i == 7) p = 8'hFF;
      ovflIn = p; tick(3);
      rd(3'd3, d); check("R4 level status", d, p);
      rd(3'd3, d); check("R4 read keeps level", d, p);
      check("R9 ovfl pin", {irqOut, irqOe}, pinExp(0, p != 0));
      rd(3'd2, d); check("R3 summary bit", d, (p != 0) ? 8'h04 : 8'h00);
      ovflIn = 8'h00; tick(3);
    end

    // R5 overflow edge mode
    wr(3'd0, 8'h04);
    for (int i = 1; i < 9; i++) begin
      logic [7:0] p;
      p = 8'((i * 8'h35) + 8'h11);
      ovflIn = p; tick(1); ovflIn = 8'h00; tick(3);
      rd(3'd3, d); check("R5 sticky", d, p);
      rd(3'd3, d); check("R5 read clear", d, 0);
    end

    // R3 overflow recorded while masked, summary and pin quiet
    wr(3'd1, 8'h00);
    ovflIn = 8'hA5; tick(1); ovflIn = 8'h00; tick(3);
    rd(3'd2, d); check("R3 summary masked", d, 0);
    check("R3 pin quiet", {irqOut, irqOe}, 2'b11);
    rd(3'd3, d); check("R3 ovfl recorded", d, 8'hA5);

    // R6 read and new edge in the same cycle
    wr(3'd1, 8'h04);
    ovflIn = 8'h01; tick(1); ovflIn = 8'h00; tick(3);
    ovflIn = 8'h02; tick(1); ovflIn = 8'h00; tick(1);
    rd(3'd3, d); check("R6 read before capture", d, 8'h01);
    rd(3'd3, d); check("R6 same-cycle event kept", d, 8'h02);
    rd(3'd3, d); check("R6 cleared afterwards", d, 0);

    // R8 lock / unlock
    wr(3'd1, 8'h03);
    srcLock = 1'b1; tick(3);
    check("R8 lock raises pin", {irqOut, irqOe}, 2'b01);
    srcLock = 1'b0; tick(3);
    rd(3'd2, d); check("R8 unlock clears lock", d, 8'h02);
    rd(3'd2, d); check("R8 read clears", d, 0);
    srcLock = 1'b1; tick(3);
    srcLock = 1'b0; tick(3);
    srcLock = 1'b1; tick(3);
    rd(3'd2, d); check("R8 lock clears unlock", d, 8'h01);
    rd(3'd2, d); check("R8 read clears lock", d, 0);
    wr(3'd1, 8'h01);
    srcLock = 1'b0; tick(3);
    rd(3'd2, d); check("R3 unlock masked", d, 0);
    srcLock = 1'b1; tick(3);
    srcLock = 1'b0; tick(3);
    rd(3'd2, d); check("R8 masked unlock still clears lock", d, 0);
    check("R8 pin idle", {irqOut, irqOe}, 2'b11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule